// File: doc/BRIEF.md
# Two-Wire Byte Memory Target

This block is the target side of a two-wire serial bus (clock line plus open-drain data line) placed in front of a byte-wide storage array. A bus controller selects the block with a seven-bit device address. A write places a two-byte word address, high byte first, into a persistent address pointer and then stores any number of data bytes at consecutive locations. A read returns bytes from the pointer, and the controller can keep reading for as long as it acknowledges.

Both bus lines are synchronized into the system clock domain. Start and stop conditions are found from the synchronized levels. The block pulls the data line low through an output enable, so a `sdaOe` of 1 means the line is driven low. The pointer width `ADDR_W` defaults to 11 bits, which gives a 2048-byte array, and can be raised to 13 to give an 8K map. The pointer survives between transactions and wraps from its top value back to zero. A read that names no address therefore continues from the location after the last one touched.

Top module: `twoWireMemSlave`

## Requirements
- R1: The upper seven bits of the first byte after a start are compared with `DEV_ADDR` (default 7'h50). On a match the block drives `sdaOe` high for the 9th clock. On a mismatch it never drives the line, and it ignores every following byte until the next start.
- R2: With bit 0 of the device byte at 0 (write), the next two bytes form the word address, high byte first. Only the low `ADDR_W` bits of that 16-bit value are used. Every byte is acknowledged.
- R3: Data bytes that follow the word address in one write are stored at consecutive addresses.
- R4: After a write-direction header that carries the word address, a repeated start with bit 0 at 1 (read) returns the byte at that address. Bits are sent MSB first and change only after a falling clock.
- R5: When the controller holds SDA low in the 9th clock of a read byte, the block sends the byte at the next address.
- R6: The pointer advances by one after each byte stored or sent, and it persists across transactions. A read with no address starts at the location after the last one accessed.
- R7: The pointer wraps from 2^ADDR_W-1 to 0, for both writes and reads.
- R8: A read may end in any of four ways: a high (no-acknowledge) 9th bit followed by a stop, a no-acknowledge followed by a start, a stop in the 9th clock, or a start in the 9th clock. In every case the block releases SDA. After a start, a new transaction proceeds normally.
- R9: A start or stop in the middle of a byte abandons the transfer. A partly received data byte is not stored and does not move the pointer, and SDA is released.
- R10: After reset, `sdaOe` is 0 and the pointer is 0. The array contents are not cleared by reset.
- R11: `sdaOe` rises only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level as seen on the wire |
| sdaOe | output | 1 | Pull data line low when 1 |

## Verification
The sharpest overlap is a bus condition that arrives in the same clock slot as byte handling. A start or stop can appear in the controller's acknowledge clock of a read, which is the moment the block would otherwise fetch and drive the next byte. A stop or start can also arrive mid-byte while a write byte is half shifted in. The bench provokes each of the four read endings and both mid-byte aborts. It judges them by seeing that the line is released, that a following current-address read returns the byte the pointer should name, and that an aborted byte never reaches the array.

// File: rtl/twm_pkg.sv
package twm_pkg;

  // Action strobes from the bus controller FSM to the datapath.
  typedef struct packed {
    logic driveAck;    // pull SDA low for an acknowledge slot
    logic releaseBus;  // stop pulling SDA
    logic loadTx;      // fetch byte at pointer, drive its MSB, advance pointer
    logic shiftTx;     // drive next bit of the outgoing byte
    logic takeHi;      // capture high word-address byte
    logic takeLo;      // form pointer from high byte and current byte
    logic storeByte;   // write received byte at pointer, advance pointer
  } twmStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKWAIT,
    ST_ACKHOLD,
    ST_TX,
    ST_MACK,
    ST_MACKWAIT
  } twmState_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_HI,
    K_LO,
    K_DATA
  } twmByteKind_t;

endpackage

// File: rtl/twmDatapath.sv
module twmDatapath
  import twm_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  twmStrobes_t strobes,
  output logic        startEv,
  output logic        stopEv,
  output logic        sclRise,
  output logic        sclFall,
  output logic        sclLvl,
  output logic        sdaBit,
  output logic [7:0]  rxByte,
  output logic        sdaOe
);

  localparam int HI_W      = ADDR_W - 8;
  localparam int MEM_DEPTH = 1 << ADDR_W;

  // Input synchronizers
  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic                   sclPrev;
  logic                   sdaPrev;
  logic                   sdaLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= SYNC_STAGES'({sclPipe, sclIn});
      sdaPipe <= SYNC_STAGES'({sdaPipe, sdaIn});
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclLvl  = sclPipe[SYNC_STAGES-1];
  assign sdaLvl  = sdaPipe[SYNC_STAGES-1];
  assign sdaBit  = sdaLvl;
  assign sclRise = sclLvl & ~sclPrev;
  assign sclFall = ~sclLvl & sclPrev;
  assign startEv = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopEv  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

  // Receive shifter: the completed byte is visible on the 8th rising clock
  logic [6:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (sclRise) begin
      rxShift <= rxByte[6:0];
    end
  end

  assign rxByte = {rxShift, sdaLvl};

  // Address pointer
  logic [HI_W-1:0]   hiReg;
  logic [ADDR_W-1:0] addrPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg   <= '0;
      addrPtr <= '0;
    end else begin
      if (strobes.takeHi) begin
        hiReg <= rxByte[HI_W-1:0];
      end
      if (strobes.takeLo) begin
        addrPtr <= {hiReg, rxByte};
      end else if (strobes.storeByte || strobes.loadTx) begin
        addrPtr <= addrPtr + 1'b1;
      end
    end
  end

  // Storage array, not reset
  logic [7:0] mem [MEM_DEPTH];
  logic [7:0] rdByte;

  always_ff @(posedge clk) begin
    if (strobes.storeByte) begin
      mem[addrPtr] <= rxByte;
    end
  end

  assign rdByte = mem[addrPtr];

  // Transmit path and open-drain enable
  logic [6:0] txRest;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txRest <= '0;
      sdaOe  <= 1'b0;
    end else begin
      if (strobes.loadTx) begin
        txRest <= rdByte[6:0];
        sdaOe  <= ~rdByte[7];
      end else if (strobes.shiftTx) begin
        txRest <= {txRest[5:0], 1'b0};
        sdaOe  <= ~txRest[6];
      end else if (strobes.driveAck) begin
        sdaOe  <= 1'b1;
      end else if (strobes.releaseBus) begin
        sdaOe  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/twmControl.sv
module twmControl
  import twm_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startEv,
  input  logic        stopEv,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        sdaBit,
  input  logic [7:0]  rxByte,
  output twmStrobes_t strobes
);

  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(7);

  twmState_t    state, stateNext;
  twmByteKind_t kind, kindNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic readMode, readModeNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kind     <= K_DEV;
      bitCnt   <= '0;
      readMode <= 1'b0;
    end else begin
      state    <= stateNext;
      kind     <= kindNext;
      bitCnt   <= bitCntNext;
      readMode <= readModeNext;
    end
  end

  always_comb begin
    strobes      = '0;
    stateNext    = state;
    kindNext     = kind;
    bitCntNext   = bitCnt;
    readModeNext = readMode;

    if (startEv) begin
      strobes.releaseBus = 1'b1;
      stateNext  = ST_RX;
      kindNext   = K_DEV;
      bitCntNext = '0;
    end else if (stopEv) begin
      strobes.releaseBus = 1'b1;
      stateNext  = ST_IDLE;
      bitCntNext = '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
        end

        ST_RX: begin
          if (sclRise) begin
            bitCntNext = bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) begin
              bitCntNext = '0;
              stateNext  = ST_ACKWAIT;
              unique case (kind)
                K_DEV: begin
                  if (rxByte[7:1] == DEV_ADDR) begin
                    readModeNext = rxByte[0];
                  end else begin
                    stateNext = ST_IDLE;
                  end
                end
                K_HI:   strobes.takeHi    = 1'b1;
                K_LO:   strobes.takeLo    = 1'b1;
                K_DATA: strobes.storeByte = 1'b1;
                default: ;
              endcase
            end
          end
        end

        ST_ACKWAIT: begin
          if (sclFall) begin
            strobes.driveAck = 1'b1;
            stateNext = ST_ACKHOLD;
          end
        end

        ST_ACKHOLD: begin
          if (sclFall) begin
            bitCntNext = '0;
            if (kind == K_DEV && readMode) begin
              strobes.loadTx = 1'b1;
              stateNext = ST_TX;
            end else begin
              strobes.releaseBus = 1'b1;
              stateNext = ST_RX;
              unique case (kind)
                K_DEV:   kindNext = K_HI;
                K_HI:    kindNext = K_LO;
                default: kindNext = K_DATA;
              endcase
            end
          end
        end

        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              strobes.releaseBus = 1'b1;
              stateNext = ST_MACK;
            end else begin
              strobes.shiftTx = 1'b1;
              bitCntNext = bitCnt + 1'b1;
            end
          end
        end

        ST_MACK: begin
          if (sclRise) begin
            stateNext = sdaBit ? ST_IDLE : ST_MACKWAIT;
          end
        end

        ST_MACKWAIT: begin
          if (sclFall) begin
            strobes.loadTx = 1'b1;
            bitCntNext = '0;
            stateNext  = ST_TX;
          end
        end

        default: stateNext = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/twoWireMemSlave.sv
module twoWireMemSlave
  import twm_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_W      = 11,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  twmStrobes_t strobes;
  logic        startEv;
  logic        stopEv;
  logic        sclRise;
  logic        sclFall;
  logic        sclLvl;
  logic        sdaBit;
  logic [7:0]  rxByte;

  twmControl #(
    .DEV_ADDR (DEV_ADDR)
  ) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startEv (startEv),
    .stopEv  (stopEv),
    .sclRise (sclRise),
    .sclFall (sclFall),
    .sdaBit  (sdaBit),
    .rxByte  (rxByte),
    .strobes (strobes)
  );

  twmDatapath #(
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) dpath (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .strobes (strobes),
    .startEv (startEv),
    .stopEv  (stopEv),
    .sclRise (sclRise),
    .sclFall (sclFall),
    .sclLvl  (sclLvl),
    .sdaBit  (sdaBit),
    .rxByte  (rxByte),
    .sdaOe   (sdaOe)
  );

endmodule

// File: rtl/twmChecker.sv
module twmChecker
  import twm_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        sdaOe,
  input logic        sclLvl,
  input logic        sclRise,
  input logic        sclFall,
  input logic        startEv,
  input logic        stopEv,
  input twmStrobes_t strobes
);

  a_r11_drive_low_clock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclLvl);

  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaOe);

  a_r9_start_releases: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> !sdaOe);

  a_r3_store_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeByte |-> sclRise);

  a_r4_fetch_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadTx |-> sclFall);

  a_r6_single_pointer_move: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.storeByte, strobes.loadTx, strobes.takeLo}));

endmodule

bind twoWireMemSlave twmChecker chk (.*);

// File: tb/twoWireMemSlave_test.sv
module twoWireMemSlave_test;

  localparam int ADDR_W = 11;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int MASK   = DEPTH - 1;
  localparam int PH     = 8;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic line;

  assign line = sdaM & ~sdaOe;

  always #2 clk = ~clk;

  twoWireMemSlave uut (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclM),
    .sdaIn (line),
    .sdaOe (sdaOe)
  );

  int checks = 0;
  int errors = 0;
  int riseViol = 0;
  bit done = 1'b0;
  logic prevOe = 1'b0;

  logic [7:0] refMem [DEPTH];
  int refPtr = 0;

  // R11 monitor: enable may only rise while the bus clock is low
  always @(posedge clk) begin
    if (rstN && sdaOe && !prevOe && sclM) riseViol++;
    prevOe <= sdaOe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt();
    repeat (PH) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaM = 1'b1; wt();
    sclM = 1'b1; wt();
    sdaM = 1'b0; wt();
    sclM = 1'b0; wt();
  endtask

  task automatic busStop();
    sdaM = 1'b0; wt();
    sclM = 1'b1; wt();
    sdaM = 1'b1; wt();
    wt();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; wt();
      sclM = 1'b1; wt();
      sclM = 1'b0; wt();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    sdaM = 1'b1; wt();
    sclM = 1'b1; wt();
    acked = ~line;
    sclM = 1'b0; wt();
  endtask

  task automatic readByte(output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt();
      sclM = 1'b1; wt();
      b[i] = line;
      sclM = 1'b0;
    end
    wt();
  endtask

  task automatic masterAck(input logic bitVal);
    sdaM = bitVal; wt();
    sclM = 1'b1; wt();
    sclM = 1'b0; wt();
    sdaM = 1'b1;
  endtask

  // Write-direction header with word address; junk placed above ADDR_W (R2)
  task automatic setAddr(input int a);
    logic ak;
    logic [15:0] w;
    w = 16'(a & MASK) | 16'hB000;
    busStart();
    sendByte({DEV, 1'b0}, ak); chk("R1 device ack", int'(ak), 1);
    sendByte(w[15:8], ak);     chk("R2 addr hi ack", int'(ak), 1);
    sendByte(w[7:0], ak);      chk("R2 addr lo ack", int'(ak), 1);
  endtask

  task automatic writeBurst(input int a, input int n, input int seed);
    logic ak;
    logic [7:0] d;
    setAddr(a);
    for (int k = 0; k < n; k++) begin
      d = 8'((seed + k * 37) & 8'hFF);
      sendByte(d, ak);
      chk("R3 data ack", int'(ak), 1);
      refMem[(a + k) & MASK] = d;
    end
    busStop();
    refPtr = (a + n) & MASK;
  endtask

  task automatic readBody(input int n, input string tag);
    logic ak;
    logic [7:0] d;
    sendByte({DEV, 1'b1}, ak);
    chk({tag, " read device ack"}, int'(ak), 1);
    for (int k = 0; k < n; k++) begin
      readByte(d);
      chk(tag, int'(d), int'(refMem[(refPtr + k) & MASK]));
      masterAck((k == n - 1) ? 1'b1 : 1'b0);
    end
    busStop();
    refPtr = (refPtr + n) & MASK;
  endtask

  task automatic readSel(input int a, input int n, input string tag);
    setAddr(a);
    refPtr = a & MASK;
    busStart();
    readBody(n, tag);
  endtask

  task automatic readCur(input int n, input string tag);
    busStart();
    readBody(n, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic [7:0] d;
    int bases [4];
    bases = '{0, 'h123, 'h400, 'h3F0};

    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset enable low", int'(sdaOe), 0);
    rstN = 1'b1;
    wt();

    // R2/R3/R4/R5: bursts at several bases, read back selectively
    foreach (bases[i]) begin
      writeBurst(bases[i], 8, 17 * i + 5);
      readSel(bases[i], 8, "R4 R5 selective sequential");
      // R6: pointer continues after the last byte read
      readCur(1, "R6 current follows last read");
      refPtr = (refPtr - 1) & MASK;
    end

    // R6: current read after a write
    writeBurst('h200, 3, 99);
    readCur(2, "R6 current follows last write");

    // R7: wrap on write and on read
    writeBurst(MASK - 1, 4, 201);
    chk("R7 write wrap low", int'(refMem[0]), int'(8'((201 + 2 * 37) & 8'hFF)));
    readSel(MASK - 2, 5, "R7 read across wrap");
    writeBurst(MASK, 1, 77);
    readCur(1, "R7 current read at zero");

    // R8: four read endings
    for (int mode = 0; mode < 4; mode++) begin
      writeBurst('h300 + 4 * mode, 2, 50 + mode);
      setAddr('h300 + 4 * mode);
      refPtr = 'h300 + 4 * mode;
      busStart();
      sendByte({DEV, 1'b1}, ak);
      chk("R8 read device ack", int'(ak), 1);
      readByte(d);
      chk("R8 first byte", int'(d), int'(refMem[refPtr]));
      refPtr = (refPtr + 1) & MASK;
      case (mode)
        0: begin masterAck(1'b1); busStop(); end
        1: begin masterAck(1'b1); busStart(); end
        2: busStop();
        default: busStart();
      endcase
      chk("R8 released after ending", int'(sdaOe), 0);
      if (mode == 0 || mode == 2) busStart();
      readBody(1, "R8 next transaction");
    end

    // R9: stop mid data byte
    writeBurst('h050, 1, 8'hC3 - 0);
    setAddr('h050);
    sendBits(8'h3C, 4);
    busStop();
    chk("R9 released after stop abort", int'(sdaOe), 0);
    readSel('h050, 1, "R9 stop abort not stored");
    // R9: start mid data byte, pointer unchanged
    setAddr('h050);
    sendBits(8'hA5, 3);
    refPtr = 'h050;
    busStart();
    readBody(1, "R9 start abort not stored");

    // R1: foreign device address
    busStart();
    sendByte({7'h51, 1'b0}, ak); chk("R1 foreign write not acked", int'(ak), 0);
    sendByte(8'h00, ak);         chk("R1 later byte ignored", int'(ak), 0);
    sendByte(8'h50, ak);         chk("R1 later byte ignored", int'(ak), 0);
    sendByte(8'h99, ak);         chk("R1 later byte ignored", int'(ak), 0);
    busStop();
    busStart();
    sendByte({7'h51, 1'b1}, ak); chk("R1 foreign read not acked", int'(ak), 0);
    readByte(d);                 chk("R1 foreign read bus idle", int'(d), 8'hFF);
    masterAck(1'b1);
    busStop();
    readSel('h050, 1, "R1 foreign write had no effect");

    // R10: pointer back to zero, array kept
    rstN = 1'b0; wt();
    chk("R10 enable low in reset", int'(sdaOe), 0);
    rstN = 1'b1; wt();
    refPtr = 0;
    readCur(1, "R10 pointer zero after reset");

    chk("R11 enable rises only with clock low", riseViol, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule